// File: doc/BRIEF.md
# Calendar Real-Time Clock

This block keeps wall-clock time and date. It receives a clock enable that pulses at 32.768 kHz. A prescaler turns those pulses into one tick per second. Each tick advances seconds. A carry then ripples through minutes, hours, day of month, month and year. The length of each month, including February in leap years, is decoded from the current month and year. The year is held as a 5-bit offset from the base year 1992, which gives a 32-year span.

Software reads and presets the fields through a small register port.

- Writes take effect on the clock edge at which `wr_en` is high.
- Reads are combinational, from `rd_addr` to `rd_data`.

Writing a time field restarts the one-second interval, so a preset time begins a full second later. Every tick also sets a sticky busy flag. Software clears the flag, reads the fields, and then checks the flag again. If the flag is set, an update overlapped the read and the read must be repeated.

Top module: `rtc_calendar`

## Requirements
- R1: With the default divider, a tick occurs on every 32768th cycle in which `osc_en` is high. The divider is the `PRESCALE` parameter. Cycles with `osc_en` low leave the prescaler and all fields unchanged.
- R2: Seconds (address 0) and minutes (address 1) count 0 to 59. A tick that finds seconds at 59 or above sets seconds to 0 and advances minutes. Minutes behave the same way with respect to hours.
- R3: Hours (address 2) count 0 to 23. An advance that finds hours at 23 or above sets hours to 0 and advances the day.
- R4: Day (address 3) counts from 1 up to the length of the current month, then wraps to 1 and advances the month. The month lengths are:
  - 30 days for months 4, 6, 9 and 11;
  - 31 days for every other month except February;
  - 28 days for month 2, or 29 when the year offset modulo 4 is 0 (offset 0 is 1992).
- R5: Month (address 4) counts 1 to 12. An advance that finds month 12 or above sets month to 1 and advances the year.
- R6: Year (address 5) counts 0 to 31. Advancing from 31 returns it to 0.
- R7: A write to addresses 0 to 5 loads that field with the low bits of `wr_data` that fit its width. Seconds and minutes are 6 bits wide. Hours, day and year are 5 bits wide. Month is 4 bits wide. The same write restarts the prescaler and suppresses any tick due in that cycle, so the next tick follows after PRESCALE further enabled cycles.
- R8: The busy flag is read as bit 0 of address 6. It sets on every tick and stays set until a write to address 6 with data bit 0 at 1. A write to address 6 with bit 0 at 0 has no effect. A tick in the same cycle as a clear wins. Writes to address 6 do not restart the prescaler.
- R9: Reads return the field value zero-extended to 6 bits. Address 6 returns the busy flag in bit 0 and zeros above it. Address 7 returns 0.
- R10: Reset, synchronous and active high, sets the following state:
  - seconds, minutes and hours to 0;
  - day and month to 1;
  - year to 0;
  - busy to 0;
  - the prescaler to the start of its interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_en | input | 1 | 32.768 kHz clock-enable pulse |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address (0 sec, 1 min, 2 hour, 3 day, 4 month, 5 year, 6 status) |
| wr_data | input | 6 | Write data |
| rd_addr | input | 3 | Read address, same map |
| rd_data | output | 6 | Combinational read data |

## Verification
The bench targets each rollover boundary. A design that compared one count too early or too late would skip 59 or show 60.

February is tested in both a leap and a common year. A 30-day month and a 31-day month are also tested. A wrong month or leap decode would skip a day or show a nonexistent date.

The full year-end ripple and the wrap from year 31 to 0 are exercised. So are out-of-range presets, which catch a rollover compare written as equality.

Writes are timed into the same cycle as a due tick. A design that let the tick through, or let a clear beat a concurrent tick, would advance a preset field or lose the busy indication.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int NFIELD  = 6;
    localparam int FIELD_W = 6;
    localparam int ADDR_W  = 3;

    typedef enum logic [ADDR_W-1:0] {
        A_SEC   = 3'd0,
        A_MIN   = 3'd1,
        A_HOUR  = 3'd2,
        A_DAY   = 3'd3,
        A_MONTH = 3'd4,
        A_YEAR  = 3'd5,
        A_STAT  = 3'd6,
        A_NONE  = 3'd7
    } rtc_addr_e;

    typedef logic [FIELD_W-1:0] fval_t;

    typedef struct packed {
        logic              we;
        logic [ADDR_W-1:0] addr;
        fval_t             data;
    } cpu_wr_t;

    function automatic int fld_width(input int idx);
        case (idx)
            0, 1:    return 6;
            4:       return 4;
            default: return 5;
        endcase
    endfunction

    function automatic int fld_low(input int idx);
        return (idx == 3 || idx == 4) ? 1 : 0;
    endfunction

    function automatic logic is_leap(input fval_t year_off);
        return (year_off[1:0] == 2'b00);
    endfunction

    function automatic fval_t days_in_month(input fval_t month, input logic leap);
        case (month)
            6'd2:                      return leap ? 6'd29 : 6'd28;
            6'd4, 6'd6, 6'd9, 6'd11:   return 6'd30;
            default:                   return 6'd31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
    parameter int DIV = 32768
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic restart,
    output logic tick
);
    localparam int CNT_W = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

    logic [CNT_W-1:0] cnt;

    assign tick = en && !restart && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt <= '0;
        end else if (en) begin
            cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
        end
    end

    assert_cnt_range_R1: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST);

    assert_idle_hold_R1: assert property (@(posedge clk) disable iff (rst)
        !en && !restart |=> $stable(cnt));

    assert_restart_zero_R7: assert property (@(posedge clk) disable iff (rst)
        restart |=> (cnt == '0));

endmodule

// File: rtl/rtc_field.sv
module rtc_field #(
    parameter int W   = 6,
    parameter int LOW = 0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc,
    input  logic [W-1:0] top,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] val,
    output logic         carry
);
    localparam logic [W-1:0] START = W'(LOW);

    logic at_top;
    assign at_top = (val >= top);
    assign carry  = inc && !load && at_top;

    always_ff @(posedge clk) begin
        if (rst) begin
            val <= START;
        end else if (load) begin
            val <= load_val;
        end else if (inc) begin
            val <= at_top ? START : val + 1'b1;
        end
    end

    assert_step_up_R2: assert property (@(posedge clk) disable iff (rst)
        inc && !load && (val < top) |=> (val == $past(val) + 1'b1));

    assert_wrap_low_R5: assert property (@(posedge clk) disable iff (rst)
        carry |=> (val == START));

    assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !inc && !load |=> $stable(val));

    assert_load_R7: assert property (@(posedge clk) disable iff (rst)
        load |=> (val == $past(load_val)));

endmodule

// File: rtl/rtc_chain.sv
module rtc_chain
    import rtc_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        tick,
    input  cpu_wr_t                     wr,
    output logic [NFIELD-1:0][FIELD_W-1:0] vals
);
    logic [NFIELD-1:0] inc;
    logic [NFIELD-1:0] carry;
    logic [NFIELD-1:0] load;
    fval_t             tops [NFIELD];

    always_comb begin
        tops[0] = 6'd59;
        tops[1] = 6'd59;
        tops[2] = 6'd23;
        tops[3] = days_in_month(vals[4], is_leap(vals[5]));
        tops[4] = 6'd12;
        tops[5] = 6'd31;
    end

    for (genvar g = 0; g < NFIELD; g++) begin : g_fld
        localparam int W = fld_width(g);
        logic [W-1:0] fv;

        assign load[g] = wr.we && (wr.addr == ADDR_W'(g));

        if (g == 0) begin : g_first
            assign inc[g] = tick;
        end else begin : g_next
            assign inc[g] = carry[g-1];
            assert_ripple_gate_R3: assert property (@(posedge clk) disable iff (rst)
                inc[g] |-> inc[g-1]);
        end

        rtc_field #(
            .W   (W),
            .LOW (fld_low(g))
        ) u_field (
            .clk      (clk),
            .rst      (rst),
            .inc      (inc[g]),
            .top      (tops[g][W-1:0]),
            .load     (load[g]),
            .load_val (wr.data[W-1:0]),
            .val      (fv),
            .carry    (carry[g])
        );

        assign vals[g] = FIELD_W'(fv);
    end

    assert_year_wrap_R6: assert property (@(posedge clk) disable iff (rst)
        carry[NFIELD-1] |=> (vals[NFIELD-1] == '0));

    assert_day_limit_R4: assert property (@(posedge clk) disable iff (rst)
        inc[3] && !load[3] && !load[4] && !load[5] && (vals[3] < 6'd28) |=> (vals[3] != 6'd1));

endmodule

// File: rtl/rtc_status.sv
module rtc_status (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic clr,
    output logic busy
);
    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
        end else if (tick) begin
            busy <= 1'b1;
        end else if (clr) begin
            busy <= 1'b0;
        end
    end

    assert_busy_set_R8: assert property (@(posedge clk) disable iff (rst)
        tick |=> busy);

    assert_busy_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        busy && !clr |=> busy);

    assert_busy_clear_R8: assert property (@(posedge clk) disable iff (rst)
        clr && !tick |=> !busy);

endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
    import rtc_pkg::*;
#(
    parameter int PRESCALE = 32768
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              osc_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [FIELD_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [FIELD_W-1:0] rd_data
);
    cpu_wr_t wr;
    logic    tick;
    logic    restart;
    logic    clr;
    logic    busy;
    logic [NFIELD-1:0][FIELD_W-1:0] vals;

    assign wr      = '{we: wr_en, addr: wr_addr, data: wr_data};
    assign restart = wr_en && (wr_addr < ADDR_W'(NFIELD));
    assign clr     = wr_en && (wr_addr == A_STAT) && wr_data[0];

    rtc_prescaler #(.DIV(PRESCALE)) u_presc (
        .clk     (clk),
        .rst     (rst),
        .en      (osc_en),
        .restart (restart),
        .tick    (tick)
    );

    rtc_chain u_chain (
        .clk  (clk),
        .rst  (rst),
        .tick (tick),
        .wr   (wr),
        .vals (vals)
    );

    rtc_status u_stat (
        .clk  (clk),
        .rst  (rst),
        .tick (tick),
        .clr  (clr),
        .busy (busy)
    );

    always_comb begin
        case (rtc_addr_e'(rd_addr))
            A_SEC:   rd_data = vals[0];
            A_MIN:   rd_data = vals[1];
            A_HOUR:  rd_data = vals[2];
            A_DAY:   rd_data = vals[3];
            A_MONTH: rd_data = vals[4];
            A_YEAR:  rd_data = vals[5];
            A_STAT:  rd_data = FIELD_W'(busy);
            default: rd_data = '0;
        endcase
    end

    assert_write_blocks_tick_R7: assert property (@(posedge clk) disable iff (rst)
        restart |-> !tick);

    assert_reset_state_R10: assert property (@(posedge clk)
        $past(rst) |-> (vals[0] == '0) && (vals[3] == 6'd1) && (vals[4] == 6'd1) && !busy);

endmodule

// File: tb/rtc_calendar_tb.sv
module rtc_calendar_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       osc_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [5:0] wr_data = '0;
    logic [2:0] rd_addr = '0;
    logic [5:0] rd_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [2:0] addr;
        logic [5:0] exp;
        string      tag;
    } item_t;

    item_t sb[$];

    always #4 clk = ~clk;

    rtc_calendar #(.PRESCALE(4)) u_dut (
        .clk     (clk),
        .rst     (rst),
        .osc_en  (osc_en),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    // monitor: pops expected items and compares against the read port
    initial begin
        forever begin
            @(negedge clk);
            if (sb.size() > 0) begin
                item_t it;
                it = sb[0];
                rd_addr = it.addr;
                #1;
                checks++;
                if (rd_data !== it.exp) begin
                    errors++;
                    $display("FAIL %s addr %0d actual %0d expected %0d",
                             it.tag, it.addr, rd_data, it.exp);
                end
                void'(sb.pop_front());
            end
        end
    end

    task automatic expect_rd(input logic [2:0] a, input logic [5:0] e, input string tag);
        item_t it;
        it.addr = a;
        it.exp  = e;
        it.tag  = tag;
        sb.push_back(it);
        while (sb.size() != 0) @(posedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [5:0] d, input bit with_en);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        osc_en  = with_en;
        @(negedge clk);
        wr_en  = 1'b0;
        osc_en = 1'b0;
    endtask

    task automatic pulse(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            osc_en = 1'b1;
        end
        @(negedge clk);
        osc_en = 1'b0;
    endtask

    task automatic set_time(input logic [5:0] y, input logic [5:0] mo, input logic [5:0] d,
                            input logic [5:0] h, input logic [5:0] mi, input logic [5:0] s);
        wr(3'd5, y, 1'b0);
        wr(3'd4, mo, 1'b0);
        wr(3'd3, d, 1'b0);
        wr(3'd2, h, 1'b0);
        wr(3'd1, mi, 1'b0);
        wr(3'd0, s, 1'b0);
    endtask

    task automatic expect_date(input logic [5:0] y, input logic [5:0] mo, input logic [5:0] d,
                               input logic [5:0] h, input logic [5:0] mi, input logic [5:0] s,
                               input string tag);
        expect_rd(3'd5, y, tag);
        expect_rd(3'd4, mo, tag);
        expect_rd(3'd3, d, tag);
        expect_rd(3'd2, h, tag);
        expect_rd(3'd1, mi, tag);
        expect_rd(3'd0, s, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R10 reset state
        expect_date(6'd0, 6'd1, 6'd1, 6'd0, 6'd0, 6'd0, "R10");
        expect_rd(3'd6, 6'd0, "R10");

        // R1 three enables: no tick; fourth: tick
        pulse(3);
        expect_rd(3'd0, 6'd0, "R1");
        expect_rd(3'd6, 6'd0, "R1");
        pulse(1);
        expect_rd(3'd0, 6'd1, "R1");
        expect_rd(3'd6, 6'd1, "R8");
        repeat (10) @(negedge clk);
        expect_rd(3'd0, 6'd1, "R1");

        // R8 clear with bit0 = 0 ignored, bit0 = 1 clears
        wr(3'd6, 6'd0, 1'b0);
        expect_rd(3'd6, 6'd1, "R8");
        wr(3'd6, 6'd1, 1'b0);
        expect_rd(3'd6, 6'd0, "R8");
        expect_rd(3'd0, 6'd1, "R8");

        // R2 seconds into minutes
        set_time(6'd3, 6'd7, 6'd10, 6'd5, 6'd5, 6'd59);
        pulse(4);
        expect_date(6'd3, 6'd7, 6'd10, 6'd5, 6'd6, 6'd0, "R2");

        // R2 minutes into hours
        set_time(6'd3, 6'd7, 6'd10, 6'd5, 6'd59, 6'd59);
        pulse(4);
        expect_date(6'd3, 6'd7, 6'd10, 6'd6, 6'd0, 6'd0, "R2");

        // R3 hours into day
        set_time(6'd3, 6'd7, 6'd10, 6'd23, 6'd59, 6'd59);
        pulse(4);
        expect_date(6'd3, 6'd7, 6'd11, 6'd0, 6'd0, 6'd0, "R3");

        // R4 30-day month
        set_time(6'd3, 6'd4, 6'd30, 6'd23, 6'd59, 6'd59);
        pulse(4);
        expect_date(6'd3, 6'd5, 6'd1, 6'd0, 6'd0, 6'd0, "R4");

        // R4 31-day month: day 30 does not wrap
        set_time(6'd3, 6'd1, 6'd30, 6'd23, 6'd59, 6'd59);
        pulse(4);
        expect_date(6'd3, 6'd1, 6'd31, 6'd0, 6'd0, 6'd0, "R4");

        // R4 common-year February (offset 1)
        set_time(6'd1, 6'd2, 6'd28, 6'd23, 6'd59, 6'd59);
        pulse(4);
        expect_date(6'd1, 6'd3, 6'd1, 6'd0, 6'd0, 6'd0, "R4");

        // R4 leap-year February (offset 0 and 4)
        set_time(6'd0, 6'd2, 6'd28, 6'd23, 6'd59, 6'd59);
        pulse(4);
        expect_date(6'd0, 6'd2, 6'd29, 6'd0, 6'd0, 6'd0, "R4");
        set_time(6'd4, 6'd2, 6'd29, 6'd23, 6'd59, 6'd59);
        pulse(4);
        expect_date(6'd4, 6'd3, 6'd1, 6'd0, 6'd0, 6'd0, "R4");

        // R5 year end
        set_time(6'd5, 6'd12, 6'd31, 6'd23, 6'd59, 6'd59);
        pulse(4);
        expect_date(6'd6, 6'd1, 6'd1, 6'd0, 6'd0, 6'd0, "R5");

        // R6 year 31 wraps to 0
        set_time(6'd31, 6'd12, 6'd31, 6'd23, 6'd59, 6'd59);
        pulse(4);
        expect_date(6'd0, 6'd1, 6'd1, 6'd0, 6'd0, 6'd0, "R6");

        // R2 / R9 out-of-range seconds preset wraps on next tick
        set_time(6'd2, 6'd6, 6'd15, 6'd8, 6'd20, 6'h3F);
        expect_rd(3'd0, 6'd63, "R9");
        pulse(4);
        expect_rd(3'd0, 6'd0, "R2");
        expect_rd(3'd1, 6'd21, "R2");

        // R7 / R9 field width truncation
        wr(3'd2, 6'h3F, 1'b0);
        expect_rd(3'd2, 6'd31, "R7");
        wr(3'd4, 6'h3F, 1'b0);
        expect_rd(3'd4, 6'd15, "R7");
        expect_rd(3'd7, 6'd0, "R9");

        // R7 write wins over a tick in the same cycle
        wr(3'd6, 6'd1, 1'b0);
        wr(3'd0, 6'd10, 1'b0);
        pulse(3);
        wr(3'd0, 6'd20, 1'b1);
        expect_rd(3'd0, 6'd20, "R7");
        expect_rd(3'd6, 6'd0, "R7");
        pulse(3);
        expect_rd(3'd0, 6'd20, "R7");
        pulse(1);
        expect_rd(3'd0, 6'd21, "R7");

        // R8 tick beats a clear in the same cycle
        wr(3'd6, 6'd1, 1'b0);
        expect_rd(3'd6, 6'd0, "R8");
        pulse(3);
        wr(3'd6, 6'd1, 1'b1);
        expect_rd(3'd6, 6'd1, "R8");
        expect_rd(3'd0, 6'd22, "R8");

        // R10 reset mid-run
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        expect_date(6'd0, 6'd1, 6'd1, 6'd0, 6'd0, 6'd0, "R10");
        expect_rd(3'd6, 6'd0, "R10");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule